// File: doc/BRIEF.md
# Forced Disk-Change Latch

This block keeps one sticky "media changed" flag per floppy drive, two drives in all, inside a small 8-bit control register. Software sets a flag by writing a 1 to the matching bit. While a drive's flag is set and that drive is selected, the drive's disk-change indication is forced active. The combined indication is also ORed with the disk-change line from the drive cable. The result feeds the most significant bit (bit 7) of the floppy controller's digital input register.

Software has no way to clear a flag. A flag clears only in hardware: a step pulse to the drive while that drive is selected clears it. The step and drive-select lines can change at any time, so both are synchronised first. A step is recognised on the rising edge of its synchronised copy.

There are three active-low resets: main power-on, bus and standby power-on. Any one of them returns the register to 0x03, so both flags come up set. All data pins are plain register-style control and status signals. The block has no streaming path and therefore no valid/ready handshake or back-pressure.

Top module: `fdc_chg_force`

## Requirements
- R1: While any of `rst_main_n`, `rst_bus_n` or `rst_stby_n` is low, `reg_rdata` reads 0x03 (bit 0 = drive-0 flag, bit 1 = drive-1 flag, both set).
- R2: A clock edge with `reg_wr` high and `reg_wdata[k]` = 1 sets flag k (k = 0 or 1), which then reads back as 1 in `reg_rdata[k]`.
- R3: Writing 0 to a flag bit leaves that flag unchanged; software can never clear a flag.
- R4: `reg_rdata[7:2]` always reads 0, and writes to those bits have no effect.
- R5: Flag 0 is cleared by a rising edge of `step_in` while `drv0_sel` is high; a step while only drive 1 is selected leaves flag 0 set.
- R6: Flag 1 is cleared by a rising edge of `step_in` while `drv1_sel` is high; a step while only drive 0 is selected leaves flag 1 set.
- R7: `chg_out` = (drive-0 select AND flag 0) OR (drive-1 select AND flag 1) OR `ext_chg`, with `ext_chg` passing through with no clock delay.
- R8: If a software set and a hardware clear hit the same flag on one clock edge, the flag ends up cleared.
- R9: With the default two-stage synchroniser, a flag is still set after the second rising clock edge following the rise of `step_in`, and cleared after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_main_n | input | 1 | Main power-on reset, active low, asynchronous |
| rst_bus_n | input | 1 | Bus reset, active low, asynchronous |
| rst_stby_n | input | 1 | Standby power-on reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe, one write per cycle it is high |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: flags in bits 1:0, zeros above |
| drv0_sel | input | 1 | Drive 0 selected, active high, asynchronous |
| drv1_sel | input | 1 | Drive 1 selected, active high, asynchronous |
| step_in | input | 1 | Head-step pulse, active high, asynchronous |
| ext_chg | input | 1 | Disk-change line from the drive, active high |
| chg_out | output | 1 | Disk-change bit for bit 7 of the digital input register |

## Verification
The properties treat the synchronised select lines and the per-drive clear strobe as given. They assume that a flag changes only through a write, a clear strobe or a reset. For `chg_out` they bound only the cases where the cable line is high or no drive is selected. The stimulus changes every input on falling clock edges. It holds the selects steady for three cycles before any step, and keeps each step high for several cycles so the synchroniser always sees a clean edge. A write and a step are kept apart in every case except the one built to make them collide in a single cycle.

// File: rtl/fdc_chg_pkg.sv
package fdc_chg_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned DRV_N       = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [REG_W-1:0] FLAGS_RST = 8'h03;
endpackage

// File: rtl/fdc_chg_sync.sv
module fdc_chg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fdc_chg_step_edge.sv
module fdc_chg_step_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic step_s,
  output logic step_rise
);
  logic step_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_d <= 1'b0;
    else        step_d <= step_s;
  end

  assign step_rise = step_s & ~step_d;
endmodule

// File: rtl/fdc_chg_flags.sv
module fdc_chg_flags #(
  parameter int unsigned N     = 2,
  parameter int unsigned REG_W = 8,
  parameter logic [REG_W-1:0] RST_VAL = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic [N-1:0]     hit,
  output logic [N-1:0]     flags
);
  for (genvar g = 0; g < int'(N); g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flags[g] <= RST_VAL[g];
      else if (hit[g])           flags[g] <= 1'b0;
      else if (wr_en && wdata[g]) flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/fdc_chg_force.sv
module fdc_chg_force
  import fdc_chg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_main_n,
  input  logic             rst_bus_n,
  input  logic             rst_stby_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             drv0_sel,
  input  logic             drv1_sel,
  input  logic             step_in,
  input  logic             ext_chg,
  output logic             chg_out
);
  localparam int unsigned SW = DRV_N + 1;

  logic             rst_n;
  logic [SW-1:0]    raw_in;
  logic [SW-1:0]    sync_out;
  logic [DRV_N-1:0] sel_s;
  logic             step_s;
  logic             step_rise;
  logic [DRV_N-1:0] hit;
  logic [DRV_N-1:0] flags;

  assign rst_n  = rst_main_n & rst_bus_n & rst_stby_n;
  assign raw_in = {step_in, drv1_sel, drv0_sel};

  fdc_chg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign sel_s  = sync_out[DRV_N-1:0];
  assign step_s = sync_out[SW-1];

  fdc_chg_step_edge u_edge (
    .clk(clk), .rst_n(rst_n), .step_s(step_s), .step_rise(step_rise)
  );

  assign hit = sel_s & {DRV_N{step_rise}};

  fdc_chg_flags #(.N(DRV_N), .REG_W(REG_W), .RST_VAL(FLAGS_RST)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .hit(hit), .flags(flags)
  );

  assign reg_rdata = {{(REG_W-DRV_N){1'b0}}, flags};
  assign chg_out   = (|(sel_s & flags)) | ext_chg;
endmodule

// File: rtl/fdc_chg_force_chk.sv
module fdc_chg_force_chk #(
  parameter int unsigned N     = 2,
  parameter int unsigned REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [N-1:0]     hit,
  input logic [N-1:0]     sel_s,
  input logic             ext_chg,
  input logic             chg_out
);
  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:N] == '0);

  // R7
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_chg |-> chg_out);

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_chg && sel_s == '0) |-> !chg_out);

  for (genvar g = 0; g < int'(N); g++) begin : g_drv
    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[g] && !hit[g]) |=> reg_rdata[g]);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[g] && !hit[g]) |=> reg_rdata[g]);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> !reg_rdata[g]);
  end
endmodule

bind fdc_chg_force fdc_chg_force_chk #(.N(fdc_chg_pkg::DRV_N), .REG_W(fdc_chg_pkg::REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .hit(hit), .sel_s(sel_s), .ext_chg(ext_chg),
  .chg_out(chg_out)
);

// File: tb/test_fdc_chg_force.sv
`timescale 1ns/1ps
module test_fdc_chg_force;
  logic       clk = 1'b0;
  logic       rst_main_n = 1'b0, rst_bus_n = 1'b0, rst_stby_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       drv0_sel = 1'b0, drv1_sel = 1'b0, step_in = 1'b0, ext_chg = 1'b0;
  logic       chg_out;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fdc_chg_force i_fdc_chg_force (
    .clk(clk), .rst_main_n(rst_main_n), .rst_bus_n(rst_bus_n),
    .rst_stby_n(rst_stby_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .drv0_sel(drv0_sel), .drv1_sel(drv1_sel),
    .step_in(step_in), .ext_chg(ext_chg), .chg_out(chg_out)
  );

  // {wr, wdata[7:0], step, sel0, sel1, ext, exp_rdata[7:0], exp_chg}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03, 1'b1}, // R7 drive0 forced
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0}, // R7 none selected
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 1'b1}, // R7 drive1 forced
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h02, 1'b0}, // R5 step clears flag0
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0}, // R3 write 0 no clear
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 step clears flag1
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1}, // R7 external line
    {1'b1, 8'hFD, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 1'b1}, // R2 R4 set flag0 only
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h01, 1'b0}, // R5 drive1 step keeps flag0
    {1'b1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 1'b1}, // R2 set flag1
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, // R5 R6 both cleared
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0}  // R4 reserved ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_step();
    step_in = 1'b1; cycles(4);
    step_in = 1'b0; cycles(3);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; cycles(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_both();
    drv0_sel = 1'b1; drv1_sel = 1'b1; cycles(3);
    pulse_step();
    drv0_sel = 1'b0; drv1_sel = 1'b0; cycles(3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cycles(2);
    chk("R1 reset value", reg_rdata, 8'h03);
    rst_main_n = 1'b1; rst_bus_n = 1'b1; rst_stby_n = 1'b1;
    cycles(2);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][21]) wr(VEC[v][20:13]);
      drv0_sel = VEC[v][11]; drv1_sel = VEC[v][10]; ext_chg = VEC[v][9];
      cycles(3);
      if (VEC[v][12]) pulse_step();
      chk($sformatf("R7/vec%0d chg", v), chg_out, VEC[v][0]);
      chk($sformatf("R2-flags vec%0d rdata", v), reg_rdata, VEC[v][8:1]);
    end
    ext_chg = 1'b0; drv0_sel = 1'b0; drv1_sel = 1'b0; cycles(3);

    // R1: each reset alone restores 0x03
    clear_both(); chk("R1 pre main", reg_rdata, 8'h00);
    rst_main_n = 1'b0; cycles(1); chk("R1 main reset", reg_rdata, 8'h03);
    rst_main_n = 1'b1; cycles(1);
    clear_both();
    rst_bus_n = 1'b0; cycles(1); chk("R1 bus reset", reg_rdata, 8'h03);
    rst_bus_n = 1'b1; cycles(1);
    clear_both();
    rst_stby_n = 1'b0; cycles(1); chk("R1 standby reset", reg_rdata, 8'h03);
    rst_stby_n = 1'b1; cycles(2);

    // R9: latency through the two-stage synchroniser
    drv0_sel = 1'b1; cycles(3);
    step_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 flag0 after 2 edges", reg_rdata[0], 1'b1);
    @(negedge clk);
    chk("R9 flag0 after 3 edges", reg_rdata[0], 1'b0);
    step_in = 1'b0; cycles(3);

    // R8: set and clear on the same edge, clear wins
    wr(8'h01); chk("R2 re-set flag0", reg_rdata, 8'h03);
    step_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    chk("R8 clear beats set", reg_rdata, 8'h02);
    step_in = 1'b0; cycles(3);
    chk("R7 flag1 only drive0 sel", chg_out, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule